// File: doc/BRIEF.md
# Receive Flow Control Trigger

This block decides when a receiving Ethernet MAC should hold back the far end. It watches two independent pressure sources: the number of free receive buffers, which raises an alarm when it drops under a programmable floor, and the receive FIFO fill level, which raises an alarm when it climbs to a programmable high-water mark. Each source has its own enable and its own recovery margin. An alarm therefore clears only after the level has moved back past its threshold by that margin.

The response depends on the duplex setting. In half duplex the block holds a collision-force request high for as long as either alarm is active, so that the line logic jams incoming frames. In full duplex it never forces a collision. Instead, it emits a one-cycle pause request carrying the configured pause quanta when throttling begins. It emits a second one-cycle request carrying zero quanta when throttling ends. Building the pause frame and driving the transmit path are left to the logic downstream.

Top module: `rx_flow_trigger`

## Requirements
- R1: After reset, `collide_force` and `pause_req` are low and `pause_quanta` is zero.
- R2: With `bufs_en` high, a `free_bufs` value strictly below `bufs_floor` sets the buffer alarm at the next rising clock edge.
- R3: Once set, the buffer alarm stays set until `free_bufs >= bufs_floor + bufs_margin`. The sum is taken without wrap, so a sum above the count range keeps the alarm set while the source is enabled.
- R4: With `fifo_en` high, a `fifo_level` at or above `fifo_high` sets the FIFO alarm at the next rising clock edge.
- R5: Once set, the FIFO alarm stays set until `fifo_level + fifo_margin < fifo_high`, with the sum taken without wrap.
- R6: A source whose enable is low never sets its alarm, and an alarm that is already set clears at the next edge after its enable drops.
- R7: With `full_duplex` low, `collide_force` equals the OR of the two alarms in the same cycle, and `pause_req` stays low.
- R8: With `full_duplex` high, `collide_force` is low. When the combined alarm (the OR of both) goes from clear to set, `pause_req` is high for exactly the following cycle, with `pause_quanta` equal to `quanta_cfg`.
- R9: With `full_duplex` high, when the combined alarm goes from set to clear, `pause_req` is high for exactly the following cycle, with `pause_quanta` equal to zero.
- R10: A second source joining, or one of two sources leaving, while the combined alarm stays set, issues no pause request.
- R11: `pause_quanta` is zero in every cycle where `pause_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| full_duplex | input | 1 | 1 selects pause requests, 0 selects forced collisions |
| bufs_en | input | 1 | Enables the free-buffer source |
| free_bufs | input | BUF_W | Current count of free receive buffers |
| bufs_floor | input | BUF_W | Buffer count under which throttling starts |
| bufs_margin | input | BUF_W | Recovery margin above the floor |
| fifo_en | input | 1 | Enables the FIFO level source |
| fifo_level | input | LVL_W | Current receive FIFO occupancy |
| fifo_high | input | LVL_W | High-water mark at which throttling starts |
| fifo_margin | input | LVL_W | Recovery margin below the high-water mark |
| quanta_cfg | input | QUANTA_W | Pause time sent when throttling begins |
| collide_force | output | 1 | Half-duplex request to jam the line |
| pause_req | output | 1 | One-cycle pause request pulse |
| pause_quanta | output | QUANTA_W | Pause time that goes with `pause_req` |

## Verification
The hardest case to reach is a combined alarm that stays set while its contributors change underneath it. One source sets, a second joins, the first recovers, and only then does the second recover. A correct design issues exactly one pause-on and one pause-off pulse across that whole sequence. The stimulus builds this overlap on purpose, ramping the buffer count and the FIFO level in staggered steps in full duplex. A long pseudo-random phase follows that toggles duplex, enables and levels near both thresholds. Every cycle is compared against a behavioural model. A separate case sets floor plus margin above the counter range to confirm that the recovery sum does not wrap.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;

  typedef enum logic {
    SIDE_LOW  = 1'b0,
    SIDE_HIGH = 1'b1
  } side_e;

  // Alarm condition: LOW side fires under the threshold, HIGH side at or above it.
  function automatic logic arm_hit(side_e side, logic [31:0] x, logic [31:0] thr);
    if (side == SIDE_LOW) return x < thr;
    else                  return x >= thr;
  endfunction

  // Recovery condition, with one spare bit so that thr + margin cannot wrap.
  function automatic logic recovered(side_e side, logic [31:0] x,
                                     logic [31:0] thr, logic [31:0] margin);
    logic [32:0] xe, te, me;
    xe = {1'b0, x};
    te = {1'b0, thr};
    me = {1'b0, margin};
    if (side == SIDE_LOW) return xe >= (te + me);
    else                  return (xe + me) < te;
  endfunction

endpackage

// File: rtl/rxfc_level_detect.sv
module rxfc_level_detect
  import rxfc_pkg::*;
#(
  parameter int    W    = 8,
  parameter side_e SIDE = SIDE_LOW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] level,
  input  logic [W-1:0] thresh,
  input  logic [W-1:0] margin,
  output logic         trig,
  output logic         hit,
  output logic         recov
);

  localparam int PAD = 32 - W;

  logic trig_q;

  assign hit   = arm_hit(SIDE, {{PAD{1'b0}}, level}, {{PAD{1'b0}}, thresh});
  assign recov = recovered(SIDE, {{PAD{1'b0}}, level}, {{PAD{1'b0}}, thresh},
                           {{PAD{1'b0}}, margin});

  always_ff @(posedge clk) begin
    if (!rst_n)      trig_q <= 1'b0;
    else if (!en)    trig_q <= 1'b0;
    else if (trig_q) trig_q <= !recov;
    else             trig_q <= hit;
  end

  assign trig = trig_q;

  // R2 / R4: an armed source sets on the next edge
  p_arm_sets_r2_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hit) |=> trig);

  // R3 / R5: held until recovery
  p_hold_r3_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && trig && !recov) |=> trig);

  // R6: disabled source is clear
  p_disabled_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !trig);

endmodule

// File: rtl/rxfc_respond.sv
module rxfc_respond #(
  parameter int QUANTA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                trig_buf,
  input  logic                trig_fifo,
  input  logic                full_duplex,
  input  logic [QUANTA_W-1:0] quanta_cfg,
  output logic                collide_force,
  output logic                pause_req,
  output logic [QUANTA_W-1:0] pause_quanta
);

  logic                active;
  logic                active_d;
  logic                active_edge;
  logic                req_q;
  logic [QUANTA_W-1:0] quanta_q;

  assign active      = trig_buf | trig_fifo;
  assign active_edge = active ^ active_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_d <= 1'b0;
      req_q    <= 1'b0;
      quanta_q <= '0;
    end else begin
      active_d <= active;
      req_q    <= full_duplex & active_edge;
      quanta_q <= (full_duplex & active_edge & active) ? quanta_cfg : '0;
    end
  end

  assign collide_force = !full_duplex && active;
  assign pause_req     = req_q;
  assign pause_quanta  = quanta_q;

  // R7: half-duplex collision follows the alarms
  p_hd_collide_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_duplex && (trig_buf || trig_fifo)) |-> collide_force);

  // R7: no pause requests born in half duplex
  p_hd_no_pause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !full_duplex |=> !pause_req);

  // R8: rising combined alarm in full duplex yields a pause-on request
  p_pause_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (full_duplex && active && !active_d) |=>
      (pause_req && pause_quanta == $past(quanta_cfg)));

  // R9: falling combined alarm in full duplex yields a pause-off request
  p_pause_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (full_duplex && !active && active_d) |=> (pause_req && pause_quanta == '0));

  // R10: no request while the combined alarm is steady
  p_steady_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (active == active_d) |=> !pause_req);

  // R11: idle quanta is zero
  p_idle_quanta_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !pause_req |-> (pause_quanta == '0));

endmodule

// File: rtl/rx_flow_trigger.sv
module rx_flow_trigger
  import rxfc_pkg::*;
#(
  parameter int BUF_W    = 8,
  parameter int LVL_W    = 10,
  parameter int QUANTA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                full_duplex,
  input  logic                bufs_en,
  input  logic [BUF_W-1:0]    free_bufs,
  input  logic [BUF_W-1:0]    bufs_floor,
  input  logic [BUF_W-1:0]    bufs_margin,
  input  logic                fifo_en,
  input  logic [LVL_W-1:0]    fifo_level,
  input  logic [LVL_W-1:0]    fifo_high,
  input  logic [LVL_W-1:0]    fifo_margin,
  input  logic [QUANTA_W-1:0] quanta_cfg,
  output logic                collide_force,
  output logic                pause_req,
  output logic [QUANTA_W-1:0] pause_quanta
);

  logic buf_trig, buf_hit, buf_recov;
  logic fifo_trig, fifo_hit, fifo_recov;

  rxfc_level_detect #(.W(BUF_W), .SIDE(SIDE_LOW)) u_buf_det (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (bufs_en),
    .level  (free_bufs),
    .thresh (bufs_floor),
    .margin (bufs_margin),
    .trig   (buf_trig),
    .hit    (buf_hit),
    .recov  (buf_recov)
  );

  rxfc_level_detect #(.W(LVL_W), .SIDE(SIDE_HIGH)) u_fifo_det (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (fifo_en),
    .level  (fifo_level),
    .thresh (fifo_high),
    .margin (fifo_margin),
    .trig   (fifo_trig),
    .hit    (fifo_hit),
    .recov  (fifo_recov)
  );

  rxfc_respond #(.QUANTA_W(QUANTA_W)) u_respond (
    .clk           (clk),
    .rst_n         (rst_n),
    .trig_buf      (buf_trig),
    .trig_fifo     (fifo_trig),
    .full_duplex   (full_duplex),
    .quanta_cfg    (quanta_cfg),
    .collide_force (collide_force),
    .pause_req     (pause_req),
    .pause_quanta  (pause_quanta)
  );

  // R1: quiet outputs in the first cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!pause_req && pause_quanta == '0 && !collide_force));

  // R8: full duplex never forces a collision
  p_fd_no_collide_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (full_duplex && (buf_hit || fifo_hit || buf_recov || fifo_recov || 1'b1))
      |-> !collide_force);

endmodule

// File: tb/rx_flow_trigger_tb_top.sv
module rx_flow_trigger_tb_top;

  localparam int BUF_W    = 8;
  localparam int LVL_W    = 10;
  localparam int QUANTA_W = 16;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                full_duplex = 1'b0;
  logic                bufs_en = 1'b0;
  logic [BUF_W-1:0]    free_bufs = '0;
  logic [BUF_W-1:0]    bufs_floor = '0;
  logic [BUF_W-1:0]    bufs_margin = '0;
  logic                fifo_en = 1'b0;
  logic [LVL_W-1:0]    fifo_level = '0;
  logic [LVL_W-1:0]    fifo_high = '0;
  logic [LVL_W-1:0]    fifo_margin = '0;
  logic [QUANTA_W-1:0] quanta_cfg = '0;
  logic                collide_force;
  logic                pause_req;
  logic [QUANTA_W-1:0] pause_quanta;

  always #10 clk = ~clk;

  rx_flow_trigger #(.BUF_W(BUF_W), .LVL_W(LVL_W), .QUANTA_W(QUANTA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex),
    .bufs_en(bufs_en), .free_bufs(free_bufs), .bufs_floor(bufs_floor),
    .bufs_margin(bufs_margin), .fifo_en(fifo_en), .fifo_level(fifo_level),
    .fifo_high(fifo_high), .fifo_margin(fifo_margin), .quanta_cfg(quanta_cfg),
    .collide_force(collide_force), .pause_req(pause_req), .pause_quanta(pause_quanta)
  );

  int tests_run = 0;
  int tests_failed = 0;
  int cycles = 0;
  bit done = 0;
  string tag = "R1";

  // Behavioural reference state
  bit m_buf, m_fifo, m_prev, m_req;
  int m_quanta;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_buf = 0; m_fifo = 0; m_prev = 0; m_req = 0; m_quanta = 0;
    end else begin
      bit on;
      on       = m_buf || m_fifo;
      m_req    = full_duplex && (on != m_prev);
      m_quanta = (m_req && on) ? int'(quanta_cfg) : 0;
      m_prev   = on;
      if (!bufs_en) m_buf = 0;
      else if (m_buf) m_buf = !(int'(free_bufs) >= int'(bufs_floor) + int'(bufs_margin));
      else m_buf = int'(free_bufs) < int'(bufs_floor);
      if (!fifo_en) m_fifo = 0;
      else if (m_fifo) m_fifo = !(int'(fifo_level) + int'(fifo_margin) < int'(fifo_high));
      else m_fifo = int'(fifo_level) >= int'(fifo_high);
    end
  end

  task automatic check(string what, int act, int exp);
    tests_run++;
    if (act != exp) begin
      tests_failed++;
      $display("FAIL %s %s: got %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  // Compare every output against the model, away from the active edge
  task automatic compare_all();
    int exp_col;
    exp_col = (!full_duplex && (m_buf || m_fifo)) ? 1 : 0;
    check("collide_force", int'(collide_force), exp_col);  // R7 / R8
    check("pause_req", int'(pause_req), int'(m_req));      // R8 / R9 / R10
    check("pause_quanta", int'(pause_quanta), m_quanta);   // R11
  endtask

  task automatic step(int n);
    repeat (n) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  endtask

  initial begin
    wait (cycles > 150000);
    tests_run++;
    tests_failed++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bufs_floor  = 8'd8;
    bufs_margin = 8'd4;
    fifo_high   = 10'd600;
    fifo_margin = 10'd100;
    quanta_cfg  = 16'h1234;
    free_bufs   = 8'd20;
    fifo_level  = 10'd0;
    repeat (3) @(negedge clk);
    // R1: reset values
    tag = "R1";
    check("collide_force reset", int'(collide_force), 0);
    check("pause_req reset", int'(pause_req), 0);
    check("pause_quanta reset", int'(pause_quanta), 0);
    rst_n = 1'b1;
    step(2);

    // R2, R3: buffer source in half duplex
    tag = "R2"; bufs_en = 1; step(2);
    free_bufs = 8'd7; step(1);
    check("R2 buffer alarm on collide", int'(collide_force), 1);
    tag = "R3";
    free_bufs = 8'd10; step(2);
    free_bufs = 8'd11; step(2);
    check("R3 held below floor+margin", int'(collide_force), 1);
    free_bufs = 8'd12; step(1);
    check("R3 cleared at floor+margin", int'(collide_force), 0);
    step(2);

    // R4, R5: FIFO source in half duplex
    tag = "R4"; bufs_en = 0; fifo_en = 1;
    fifo_level = 10'd599; step(2);
    check("R4 below mark quiet", int'(collide_force), 0);
    fifo_level = 10'd600; step(1);
    check("R4 at mark sets", int'(collide_force), 1);
    tag = "R5";
    fifo_level = 10'd550; step(1);
    fifo_level = 10'd500; step(1);
    check("R5 held at mark-margin", int'(collide_force), 1);
    fifo_level = 10'd499; step(1);
    check("R5 cleared below mark-margin", int'(collide_force), 0);

    // R6: enable gating
    tag = "R6";
    fifo_level = 10'd900; step(2);
    fifo_en = 0; step(1);
    check("R6 disable clears", int'(collide_force), 0);
    step(3);
    free_bufs = 8'd1; step(3);
    check("R6 disabled buffer source quiet", int'(collide_force), 0);
    free_bufs = 8'd30; fifo_level = 10'd0; step(2);

    // R8, R9: full duplex pause on/off
    tag = "R8"; full_duplex = 1; bufs_en = 1; fifo_en = 1; step(2);
    free_bufs = 8'd3; step(1);
    check("R8 no collide in full duplex", int'(collide_force), 0);
    step(1);
    check("R8 pause-on pulse", int'(pause_req), 1);
    check("R8 pause-on quanta", int'(pause_quanta), 32'h1234);
    step(1);
    check("R8 pulse lasts one cycle", int'(pause_req), 0);
    tag = "R9";
    free_bufs = 8'd40; step(2);
    check("R9 pause-off pulse", int'(pause_req), 1);
    check("R9 pause-off quanta", int'(pause_quanta), 0);
    step(2);

    // R10: overlapping sources yield one on and one off pulse
    tag = "R10"; quanta_cfg = 16'h00F0;
    free_bufs = 8'd2; step(4);
    fifo_level = 10'd700; step(4);
    check("R10 second source joins quietly", int'(pause_req), 0);
    free_bufs = 8'd50; step(4);
    check("R10 first source leaves quietly", int'(pause_req), 0);
    fifo_level = 10'd10; step(2);
    check("R10 final pause-off", int'(pause_req), 1);
    step(2);

    // R3: floor+margin beyond counter range never recovers
    tag = "R3"; full_duplex = 0; fifo_en = 0;
    bufs_floor = 8'd250; bufs_margin = 8'd10;
    free_bufs = 8'd200; step(2);
    free_bufs = 8'd255; step(4);
    check("R3 no wrap of floor+margin", int'(collide_force), 1);
    bufs_en = 0; step(2);
    bufs_floor = 8'd8; bufs_margin = 8'd4;

    // Mixed pseudo-random phase, compared each cycle
    tag = "R7";
    for (int i = 0; i < 3000; i++) begin
      if (i % 97 == 0) full_duplex = ~full_duplex;
      if (i % 61 == 0) bufs_en = ~bufs_en;
      if (i % 43 == 0) fifo_en = ~fifo_en;
      tag = full_duplex ? "R10" : "R7";
      free_bufs   = 8'($urandom_range(0, 16));
      fifo_level  = 10'($urandom_range(480, 620));
      bufs_margin = 8'($urandom_range(0, 5));
      fifo_margin = 10'($urandom_range(0, 80));
      quanta_cfg  = 16'($urandom_range(1, 65535));
      step(1);
    end

    finish_run();
  end

endmodule